// File: doc/BRIEF.md
# Flash Program/Erase Timing Sequencer

This block drives the high-voltage control lines of a flash array through one program or erase session. One prescaler divides the system clock, and each timed phase lasts a set number of prescaled ticks. The ticks come from configuration registers that software loads while the block is idle. A session has these steps. The charge pump starts and the block waits out its start delay. The row is selected and the block waits out the program/erase transition. Then the high-voltage pulse is applied. When a program pulse ends, the requester may ask for another word. The block then holds the pump and row for a short fixed gap, so the address can change, and applies a further pulse. After the last pulse the pump and row stay on for one more clock. The pump then drops, and the block waits out the end delay before it returns to idle.

An erase uses the same sequence with a single pulse. Each erase count is worth four prescaled ticks, so erase pulses can be far longer than program pulses from registers of the same width. The configuration registers freeze while the block is busy. A new command is accepted only when the block is idle.

Top module: `flash_pe_sequencer`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `pump_en`, `row_sel`, `hv_pulse` and `word_adv` are all low. The configuration registers reset to zero.
- R2: `cmd_go` sampled high while idle starts a session. The first phase is the pump start delay: `pump_en` high and `row_sel` low for (DIV+1)×(START+1) clocks.
- R3: The transition phase follows. `pump_en` and `row_sel` are high and `hv_pulse` is low for (DIV+1)×(TRAN+1) clocks.
- R4: With `cmd_erase` low at the start command (program), each pulse holds `hv_pulse` high for (DIV+1)×(PROG+1) clocks.
- R5: With `cmd_erase` high at the start command (erase), the single pulse holds `hv_pulse` high for (DIV+1)×4×(ER+1) clocks.
- R6: In a program session, `word_more` high on the last clock of a pulse causes a 2-clock address gap. During the gap `pump_en` and `row_sel` stay high and `hv_pulse` is low. `word_adv` is high on the first gap clock only. Another pulse follows directly after the gap.
- R7: After the last pulse, `pump_en` and `row_sel` stay high for exactly 1 clock. Then both drop, and `busy` stays high for a further (DIV+1)×(END+1) clocks of end delay.
- R8: `busy` rises on the clock after an accepted `cmd_go` and falls when the end delay completes. `cmd_go` while busy has no effect.
- R9: `cfg_we` loads all six count registers only while idle. Writes while busy are ignored, so the next session uses the earlier values.
- R10: An erase session performs exactly one pulse and ignores `word_more`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load strobe for all count registers (idle only) |
| cfg_div | input | DIV_W | Prescaler value DIV, one tick every DIV+1 clocks |
| cfg_start | input | CNT_W | Pump start delay count START |
| cfg_tran | input | CNT_W | Transition count TRAN |
| cfg_prog | input | CNT_W | Program pulse count PROG |
| cfg_erase | input | CNT_W | Erase pulse count ER (scaled by four) |
| cfg_end | input | CNT_W | End delay count END |
| cmd_go | input | 1 | Start a session (accepted while idle) |
| cmd_erase | input | 1 | 1 = erase, 0 = program, sampled with `cmd_go` |
| word_more | input | 1 | Another word follows, sampled on the last pulse clock |
| busy | output | 1 | Session in progress |
| pump_en | output | 1 | Charge pump enable |
| row_sel | output | 1 | Row select |
| hv_pulse | output | 1 | High-voltage program/erase pulse |
| word_adv | output | 1 | One-clock request to present the next address |

## Verification
The bench builds the block with DIV_W = 4 and CNT_W = 4. This brings both extremes within reach in a short run. All counts at zero, with a tick every clock, give one-clock phases. All counts at fifteen give the longest phases: a 1024-clock erase pulse and 256-clock program pulses. A multi-word program session exercises the address gap twice. Write and start attempts made mid-session show that frozen registers carry over into the following session.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_START = 3'd1,
      PH_TRAN  = 3'd2,
      PH_PULSE = 3'd3,
      PH_ADDR  = 3'd4,
      PH_HOLD  = 3'd5,
      PH_END   = 3'd6
   } flseq_phase_e;

endpackage

// File: rtl/flseq_cfg_regs.sv
module flseq_cfg_regs #(
   parameter int DIV_W = 8,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DIV_W-1:0] div_d,
   input  logic [CNT_W-1:0] start_d,
   input  logic [CNT_W-1:0] tran_d,
   input  logic [CNT_W-1:0] prog_d,
   input  logic [CNT_W-1:0] erase_d,
   input  logic [CNT_W-1:0] end_d,
   output logic [DIV_W-1:0] div_q,
   output logic [CNT_W-1:0] start_q,
   output logic [CNT_W-1:0] tran_q,
   output logic [CNT_W-1:0] prog_q,
   output logic [CNT_W-1:0] erase_q,
   output logic [CNT_W-1:0] end_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q   <= '0;
         start_q <= '0;
         tran_q  <= '0;
         prog_q  <= '0;
         erase_q <= '0;
         end_q   <= '0;
      end else if (wr_en) begin
         div_q   <= div_d;
         start_q <= start_d;
         tran_q  <= tran_d;
         prog_q  <= prog_d;
         erase_q <= erase_d;
         end_q   <= end_d;
      end
   end

endmodule

// File: rtl/flseq_prescaler.sv
module flseq_prescaler #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (restart)
         pre_q <= div;
      else if (run)
         pre_q <= (pre_q == '0) ? div : pre_q - 1'b1;
   end

   assign tick = run && (pre_q == '0);

endmodule

// File: rtl/flseq_phase_timer.sv
module flseq_phase_timer #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] len,
   input  logic             tick,
   output logic             done,
   output logic [LEN_W-1:0] remain
);

   logic [LEN_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= len;
      else if (tick && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign done   = tick && (cnt_q == '0);
   assign remain = cnt_q;

endmodule

// File: rtl/flash_pe_sequencer.sv
module flash_pe_sequencer
   import flseq_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int CNT_W       = 8,
   parameter int ERASE_SCALE = 4,
   parameter int ADDR_GAP    = 2,
   parameter int PUMP_TAIL   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [CNT_W-1:0] cfg_start,
   input  logic [CNT_W-1:0] cfg_tran,
   input  logic [CNT_W-1:0] cfg_prog,
   input  logic [CNT_W-1:0] cfg_erase,
   input  logic [CNT_W-1:0] cfg_end,
   input  logic             cmd_go,
   input  logic             cmd_erase,
   input  logic             word_more,
   output logic             busy,
   output logic             pump_en,
   output logic             row_sel,
   output logic             hv_pulse,
   output logic             word_adv
);

   localparam int SCALE_SH = (ERASE_SCALE > 1) ? $clog2(ERASE_SCALE) : 0;
   localparam int LEN_W    = CNT_W + SCALE_SH;
   localparam int GAP_MAX  = (ADDR_GAP > PUMP_TAIL) ? ADDR_GAP : PUMP_TAIL;
   localparam int GAP_W    = (GAP_MAX > 1) ? $clog2(GAP_MAX) : 1;
   localparam logic [GAP_W-1:0] GAP_FIRST = GAP_W'(ADDR_GAP - 1);
   localparam logic [GAP_W-1:0] TAIL_LEN  = GAP_W'(PUMP_TAIL - 1);

   // elaboration-time parameter checks
   generate
      if (DIV_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("flash_pe_sequencer: DIV_W and CNT_W must be at least 1");
      end
      if (ERASE_SCALE < 1 || LEN_W > 30) begin : g_bad_scale
         $error("flash_pe_sequencer: ERASE_SCALE out of range");
      end
      if (ADDR_GAP < 1 || PUMP_TAIL < 1) begin : g_bad_gap
         $error("flash_pe_sequencer: ADDR_GAP and PUMP_TAIL must be at least 1");
      end
   endgenerate

   flseq_phase_e ph_q, ph_d;
   logic         op_q;

   logic [DIV_W-1:0] div_q;
   logic [CNT_W-1:0] start_q, tran_q, prog_q, erase_q, end_q;
   logic [LEN_W-1:0] erase_len;

   logic             main_ld, main_run, main_tick, main_done;
   logic [LEN_W-1:0] main_len, main_rem;
   logic             gap_ld, gap_run, gap_done;
   logic [GAP_W-1:0] gap_len, gap_rem;

   flseq_cfg_regs #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && (ph_q == PH_IDLE)),
      .div_d   (cfg_div),
      .start_d (cfg_start),
      .tran_d  (cfg_tran),
      .prog_d  (cfg_prog),
      .erase_d (cfg_erase),
      .end_d   (cfg_end),
      .div_q   (div_q),
      .start_q (start_q),
      .tran_q  (tran_q),
      .prog_q  (prog_q),
      .erase_q (erase_q),
      .end_q   (end_q)
   );

   // erase length in ticks, minus one: (ER+1)*SCALE-1
   generate
      if (ERASE_SCALE == 1) begin : g_er_unit
         assign erase_len = erase_q;
      end else if ((ERASE_SCALE & (ERASE_SCALE - 1)) == 0) begin : g_er_shift
         assign erase_len = {erase_q, {SCALE_SH{1'b1}}};
      end else begin : g_er_mult
         assign erase_len = LEN_W'((int'(erase_q) + 1) * ERASE_SCALE - 1);
      end
   endgenerate

   assign main_run = (ph_q == PH_START) || (ph_q == PH_TRAN) ||
                     (ph_q == PH_PULSE) || (ph_q == PH_END);
   assign gap_run  = (ph_q == PH_ADDR) || (ph_q == PH_HOLD);

   flseq_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (main_ld),
      .run     (main_run),
      .div     (div_q),
      .tick    (main_tick)
   );

   flseq_phase_timer #(.LEN_W(LEN_W)) u_main_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (main_ld),
      .len    (main_len),
      .tick   (main_tick),
      .done   (main_done),
      .remain (main_rem)
   );

   flseq_phase_timer #(.LEN_W(GAP_W)) u_gap_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (gap_ld),
      .len    (gap_len),
      .tick   (gap_run),
      .done   (gap_done),
      .remain (gap_rem)
   );

   always_comb begin
      ph_d     = ph_q;
      main_ld  = 1'b0;
      main_len = '0;
      gap_ld   = 1'b0;
      gap_len  = '0;
      unique case (ph_q)
         PH_IDLE: if (cmd_go) begin
            ph_d     = PH_START;
            main_ld  = 1'b1;
            main_len = LEN_W'(start_q);
         end
         PH_START: if (main_done) begin
            ph_d     = PH_TRAN;
            main_ld  = 1'b1;
            main_len = LEN_W'(tran_q);
         end
         PH_TRAN: if (main_done) begin
            ph_d     = PH_PULSE;
            main_ld  = 1'b1;
            main_len = op_q ? erase_len : LEN_W'(prog_q);
         end
         PH_PULSE: if (main_done) begin
            gap_ld = 1'b1;
            if (!op_q && word_more) begin
               ph_d    = PH_ADDR;
               gap_len = GAP_FIRST;
            end else begin
               ph_d    = PH_HOLD;
               gap_len = TAIL_LEN;
            end
         end
         PH_ADDR: if (gap_done) begin
            ph_d     = PH_PULSE;
            main_ld  = 1'b1;
            main_len = LEN_W'(prog_q);
         end
         PH_HOLD: if (gap_done) begin
            ph_d     = PH_END;
            main_ld  = 1'b1;
            main_len = LEN_W'(end_q);
         end
         PH_END: if (main_done) ph_d = PH_IDLE;
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= PH_IDLE;
         op_q <= 1'b0;
      end else begin
         ph_q <= ph_d;
         if ((ph_q == PH_IDLE) && cmd_go)
            op_q <= cmd_erase;
      end
   end

   assign busy     = (ph_q != PH_IDLE);
   assign pump_en  = busy && (ph_q != PH_END);
   assign row_sel  = pump_en && (ph_q != PH_START);
   assign hv_pulse = (ph_q == PH_PULSE);
   assign word_adv = (ph_q == PH_ADDR) && (gap_rem == GAP_FIRST);

endmodule

// File: rtl/flseq_checker.sv
module flseq_checker (
   input logic clk,
   input logic rst_n,
   input logic cmd_go,
   input logic busy,
   input logic pump_en,
   input logic row_sel,
   input logic hv_pulse,
   input logic word_adv,
   input logic op_erase
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!pump_en && !row_sel && !hv_pulse && !word_adv)); // R1

   AST_PUMP_LEADS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(row_sel) |-> $past(pump_en)); // R2

   AST_PULSE_AFTER_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hv_pulse) |-> $past(row_sel)); // R3

   AST_GAP_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      word_adv |=> (!hv_pulse && pump_en && row_sel)); // R6

   AST_PUMP_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hv_pulse) |-> (pump_en && row_sel)); // R7

   AST_PUMP_OFF_BEFORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !$past(pump_en)); // R7

   AST_BUSY_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_go)); // R8

   AST_ERASE_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      word_adv |-> !op_erase); // R10

endmodule

bind flash_pe_sequencer flseq_checker u_flseq_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_go   (cmd_go),
   .busy     (busy),
   .pump_en  (pump_en),
   .row_sel  (row_sel),
   .hv_pulse (hv_pulse),
   .word_adv (word_adv),
   .op_erase (op_q)
);

// File: tb/flash_pe_sequencer_bench.sv
module flash_pe_sequencer_bench;

   localparam int DIV_W = 4;
   localparam int CNT_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [DIV_W-1:0] cfg_div = '0;
   logic [CNT_W-1:0] cfg_start = '0, cfg_tran = '0, cfg_prog = '0, cfg_erase = '0, cfg_end = '0;
   logic cmd_go = 1'b0, cmd_erase = 1'b0, word_more = 1'b0;
   logic busy, pump_en, row_sel, hv_pulse, word_adv;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   flash_pe_sequencer #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_flash_pe_sequencer (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
      .cfg_start(cfg_start), .cfg_tran(cfg_tran), .cfg_prog(cfg_prog),
      .cfg_erase(cfg_erase), .cfg_end(cfg_end), .cmd_go(cmd_go),
      .cmd_erase(cmd_erase), .word_more(word_more), .busy(busy),
      .pump_en(pump_en), .row_sel(row_sel), .hv_pulse(hv_pulse),
      .word_adv(word_adv)
   );

   // reference model: phase 0 idle,1 start,2 tran,3 pulse,4 gap,5 tail,6 end
   int m_ph, m_rem;
   int m_d, m_s, m_t, m_p, m_e, m_n;
   bit m_op;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_rem = 0; m_op = 0;
         m_d = 0; m_s = 0; m_t = 0; m_p = 0; m_e = 0; m_n = 0;
      end else if (m_ph == 0) begin
         if (cmd_go) begin
            m_op = cmd_erase; m_ph = 1; m_rem = (m_d + 1) * (m_s + 1);
         end
         if (cfg_we) begin
            m_d = cfg_div; m_s = cfg_start; m_t = cfg_tran;
            m_p = cfg_prog; m_e = cfg_erase; m_n = cfg_end;
         end
      end else begin
         m_rem--;
         if (m_rem == 0) begin
            case (m_ph)
               1: begin m_ph = 2; m_rem = (m_d + 1) * (m_t + 1); end
               2: begin
                  m_ph = 3;
                  m_rem = m_op ? (m_d + 1) * 4 * (m_e + 1) : (m_d + 1) * (m_p + 1);
               end
               3: if (!m_op && word_more) begin m_ph = 4; m_rem = 2; end
                  else begin m_ph = 5; m_rem = 1; end
               4: begin m_ph = 3; m_rem = (m_d + 1) * (m_p + 1); end
               5: begin m_ph = 6; m_rem = (m_d + 1) * (m_n + 1); end
               default: m_ph = 0;
            endcase
         end
      end
   end

   function automatic string ph_tag(int ph, bit op);
      case (ph)
         0: return "R1/R8";
         1: return "R2";
         2: return "R3";
         3: return op ? "R5" : "R4";
         4: return "R6";
         default: return "R7";
      endcase
   endfunction

   // per-clock comparison and activity counters
   int busy_rises, pulse_rises, hv_cyc, start_cyc, end_cyc;
   bit prev_busy, prev_hv;

   always @(negedge clk) begin
      if (rst_n) begin
         logic [4:0] got, exp;
         got = {busy, pump_en, row_sel, hv_pulse, word_adv};
         exp = {m_ph != 0, m_ph inside {1, 2, 3, 4, 5}, m_ph inside {2, 3, 4, 5},
                m_ph == 3, (m_ph == 4) && (m_rem == 2)};
         total++;
         if (got !== exp) begin
            bad++;
            $display("FAIL %s busy/pump/row/hv/adv actual=%b expected=%b", ph_tag(m_ph, m_op), got, exp);
         end
         if (busy && !prev_busy) busy_rises++;
         if (hv_pulse && !prev_hv) pulse_rises++;
         if (hv_pulse) hv_cyc++;
         if (busy && pump_en && !row_sel) start_cyc++;
         if (busy && !pump_en) end_cyc++;
         prev_busy = busy;
         prev_hv = hv_pulse;
      end
   end

   task automatic chk(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clr();
      busy_rises = 0; pulse_rises = 0; hv_cyc = 0; start_cyc = 0; end_cyc = 0;
   endtask

   task automatic write_cfg(int d, int s, int t, int p, int e, int n);
      @(negedge clk);
      cfg_div = DIV_W'(d); cfg_start = CNT_W'(s); cfg_tran = CNT_W'(t);
      cfg_prog = CNT_W'(p); cfg_erase = CNT_W'(e); cfg_end = CNT_W'(n);
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic go(bit er);
      @(negedge clk);
      cmd_erase = er; cmd_go = 1'b1;
      @(negedge clk);
      cmd_go = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      clr();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk({busy, pump_en, row_sel, hv_pulse, word_adv} == 5'b0, "R1 outputs after reset",
          int'({busy, pump_en, row_sel, hv_pulse, word_adv}), 0);

      // minimum counts: every phase one tick of one clock
      write_cfg(0, 0, 0, 0, 0, 0);
      clr(); go(0); wait_idle();
      chk(hv_cyc == 1, "R4 min program pulse", hv_cyc, 1);
      chk(start_cyc == 1, "R2 min start delay", start_cyc, 1);
      chk(end_cyc == 1, "R7 min end delay", end_cyc, 1);

      // three-word program session
      write_cfg(2, 3, 1, 4, 0, 2);
      clr(); word_more = 1'b1; go(0);
      begin
         int n = 0;
         while (n < 2) begin
            @(negedge clk);
            if (word_adv) n++;
         end
      end
      word_more = 1'b0;
      wait_idle();
      chk(pulse_rises == 3, "R6 pulses in multi-word session", pulse_rises, 3);
      chk(hv_cyc == 45, "R4 program pulse clocks", hv_cyc, 45);
      chk(start_cyc == 12, "R2 start delay clocks", start_cyc, 12);
      chk(end_cyc == 9, "R7 end delay clocks", end_cyc, 9);

      // erase ignores word_more
      write_cfg(1, 0, 0, 0, 2, 0);
      clr(); word_more = 1'b1; go(1); wait_idle();
      word_more = 1'b0;
      chk(pulse_rises == 1, "R10 erase pulse count", pulse_rises, 1);
      chk(hv_cyc == 24, "R5 erase pulse clocks", hv_cyc, 24);

      // maximum counts
      write_cfg(15, 15, 15, 15, 15, 15);
      clr(); go(0); wait_idle();
      chk(hv_cyc == 256, "R4 max program pulse", hv_cyc, 256);
      clr(); go(1); wait_idle();
      chk(hv_cyc == 1024, "R5 max erase pulse", hv_cyc, 1024);

      // writes and commands while busy are ignored
      write_cfg(1, 2, 0, 1, 0, 0);
      clr(); go(0);
      @(negedge clk);
      cfg_div = 7; cfg_start = 7; cfg_tran = 7; cfg_prog = 7; cfg_erase = 7; cfg_end = 7;
      cfg_we = 1'b1; cmd_go = 1'b1; cmd_erase = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; cmd_go = 1'b0; cmd_erase = 1'b0;
      wait_idle();
      chk(busy_rises == 1, "R8 go while busy ignored", busy_rises, 1);
      chk(pulse_rises == 1 && hv_cyc == 4, "R8 session unchanged by go while busy", hv_cyc, 4);
      clr(); go(0); wait_idle();
      chk(start_cyc == 6, "R9 start delay keeps earlier value", start_cyc, 6);
      chk(hv_cyc == 4, "R9 pulse keeps earlier value", hv_cyc, 4);

      repeat (3) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule